// File: doc/BRIEF.md
# Transmit Interrupt Delay Controller

This block decides when a transmit-completion interrupt is raised once descriptors have been written back. On every write-back it looks at two command bits of that descriptor: report-status and delay-enable. A descriptor that asks for status and also for delay (re)starts a countdown from a programmed delay value. A descriptor that asks for status without delay raises the interrupt at once and abandons any countdown in progress.

The countdown decrements on a prescale tick input, so the time unit is set outside the block. When the count runs out, an interrupt is raised if the write-back interrupt mask bit is enabled. If the mask is disabled, the cause is held pending and is delivered once when the mask is enabled again.

All pins are plain control signals. The write-back strobe carries no handshake and is never back-pressured: the block accepts a strobe on any cycle, and each strobe takes effect at the next clock edge.

Top module: `txirq_delay_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and the pending cause are cleared and `irq_req` is 0 after that edge. Ticks that follow without any strobe produce no interrupt.
- R2: A strobe with `wb_report`=1, `wb_delay_en`=1 and a nonzero `delay_val`=D loads the counter with D. With no further reporting strobes and the mask enabled, `irq_req` is 1 in the cycle after the edge that samples the D-th `tick`.
- R3: `irq_req` is never 1 in the cycle after an edge that sampled `irq_mask_en`=0.
- R4: A delay-enabled reporting strobe that arrives while a countdown is running reloads the counter from `delay_val`. The interrupt then follows D ticks after this reload, and the earlier countdown produces no interrupt.
- R5: A strobe with `wb_report`=1 and `wb_delay_en`=0 raises `irq_req` in the cycle after the strobe, when the mask is enabled. It also stops any running countdown, so that countdown produces no later interrupt.
- R6: A delay-enabled reporting strobe with `delay_val`=0 behaves exactly like the immediate case of R5.
- R7: An interrupt event (an expiry or an immediate strobe) that occurs while `irq_mask_en`=0 is latched as pending. At the first edge that samples `irq_mask_en`=1, exactly one `irq_req` pulse follows and the pending cause is cleared.
- R8: Strobes with `wb_report`=0 change neither the counter nor the interrupt output, whatever the values of `wb_delay_en` and `delay_val`.
- R9: Each interrupt event gives a single one-cycle `irq_req` pulse. With no reporting strobe, no pending cause and no count remaining, `irq_req` does not stay high for a second cycle.
- R10: The counter moves only on edges that sample `tick`=1. When a load and a tick occur in the same cycle, the load wins and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_valid | input | 1 | One write-back event in this cycle |
| wb_report | input | 1 | Report-status command bit of the written-back descriptor |
| wb_delay_en | input | 1 | Delay-enable command bit of the written-back descriptor |
| delay_val | input | DLY_W | Programmed delay, counted in ticks |
| tick | input | 1 | Prescale pulse; one count per high cycle |
| irq_mask_en | input | 1 | Write-back interrupt mask bit (1 = enabled) |
| irq_req | output | 1 | One-cycle transmit interrupt request |

## Verification
The bench builds the block with `DLY_W`=4, which keeps the full delay range, from 0 to the all-ones value of 15, within a few cycles. Random strobes can therefore land mid-count, on the final tick, or together with a tick, and do so often. Random mask toggling produces masked expiries and pending deliveries that meet fresh events in the same cycle. Directed sequences cover reload, cancellation, zero delay and strobes without report-status while a count is running.

// File: rtl/tid_pkg.sv
package tid_pkg;
  // What one write-back strobe asks of the timer
  typedef enum logic [1:0] {
    WB_NONE = 2'd0,  // no strobe, or no status requested
    WB_FIRE = 2'd1,  // interrupt now, drop the countdown
    WB_ARM  = 2'd2   // (re)load the countdown
  } wb_kind_e;
endpackage

// File: rtl/tid_decode.sv
module tid_decode
  import tid_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             wb_valid,
  input  logic             wb_report,
  input  logic             wb_delay_en,
  input  logic [DLY_W-1:0] delay_val,
  output wb_kind_e         kind
);
  logic zero_dly;
  assign zero_dly = (delay_val == '0);

  always_comb begin
    kind = WB_NONE;
    if (wb_valid && wb_report) begin
      if (wb_delay_en && !zero_dly) kind = WB_ARM;
      else                          kind = WB_FIRE;
    end
  end
endmodule

// File: rtl/tid_timer.sv
module tid_timer
  import tid_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  wb_kind_e         kind,
  input  logic [DLY_W-1:0] delay_val,
  input  logic             tick,
  output logic [DLY_W-1:0] cnt_q,
  output logic             expire
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic running;
  assign running = (cnt_q != '0);
  // expiry only when no strobe overrides the count this cycle
  assign expire  = (kind == WB_NONE) && tick && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case (kind)
        WB_ARM:  cnt_q <= delay_val;
        WB_FIRE: cnt_q <= '0;
        default: if (tick && running) cnt_q <= cnt_q - ONE;
      endcase
    end
  end
endmodule

// File: rtl/tid_gate.sv
module tid_gate (
  input  logic clk,
  input  logic rst,
  input  logic event_in,
  input  logic mask_en,
  output logic irq_q,
  output logic pend_q
);
  logic cause;
  assign cause = event_in || pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_q  <= cause && mask_en;
      pend_q <= cause && !mask_en;
    end
  end
endmodule

// File: rtl/txirq_delay_ctrl.sv
module txirq_delay_ctrl
  import tid_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wb_valid,
  input  logic             wb_report,
  input  logic             wb_delay_en,
  input  logic [DLY_W-1:0] delay_val,
  input  logic             tick,
  input  logic             irq_mask_en,
  output logic             irq_req
);
  wb_kind_e         kind;
  logic [DLY_W-1:0] cnt_q;
  logic             expire;
  logic             fire_evt;
  logic             pend_q;

  tid_decode #(.DLY_W(DLY_W)) u_dec (
    .wb_valid    (wb_valid),
    .wb_report   (wb_report),
    .wb_delay_en (wb_delay_en),
    .delay_val   (delay_val),
    .kind        (kind)
  );

  tid_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .delay_val (delay_val),
    .tick      (tick),
    .cnt_q     (cnt_q),
    .expire    (expire)
  );

  assign fire_evt = (kind == WB_FIRE) || expire;

  tid_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .event_in (fire_evt),
    .mask_en  (irq_mask_en),
    .irq_q    (irq_req),
    .pend_q   (pend_q)
  );
endmodule

// File: rtl/txirq_delay_chk.sv
module txirq_delay_chk #(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wb_valid,
  input logic             wb_report,
  input logic             wb_delay_en,
  input logic [DLY_W-1:0] delay_val,
  input logic             tick,
  input logic             irq_mask_en,
  input logic             irq_req,
  input logic [DLY_W-1:0] cnt,
  input logic             pend
);
  logic rep;
  assign rep = wb_valid && wb_report;

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !irq_req && cnt == '0 && !pend);

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    rep && wb_delay_en && delay_val != '0 |=> cnt == $past(delay_val));

  a_r3_masked_no_irq: assert property (@(posedge clk) disable iff (rst)
    !irq_mask_en |=> !irq_req);

  a_r5_immediate: assert property (@(posedge clk) disable iff (rst)
    rep && !wb_delay_en && irq_mask_en |=> irq_req && cnt == '0);

  a_r6_zero_delay: assert property (@(posedge clk) disable iff (rst)
    rep && delay_val == '0 && irq_mask_en |=> irq_req && cnt == '0);

  a_r7_pending_once: assert property (@(posedge clk) disable iff (rst)
    pend && irq_mask_en |=> irq_req && !pend);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_req && !rep && cnt == '0 && !pend |=> !irq_req);

  a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    !tick && !rep |=> $stable(cnt));
endmodule

bind txirq_delay_ctrl txirq_delay_chk #(.DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wb_valid    (wb_valid),
  .wb_report   (wb_report),
  .wb_delay_en (wb_delay_en),
  .delay_val   (delay_val),
  .tick        (tick),
  .irq_mask_en (irq_mask_en),
  .irq_req     (irq_req),
  .cnt         (cnt_q),
  .pend        (pend_q)
);

// File: tb/sim_txirq_delay_ctrl.sv
`timescale 1ns/1ps
module sim_txirq_delay_ctrl;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wb_valid = 1'b0, wb_report = 1'b0, wb_delay_en = 1'b0;
  logic [DW-1:0] delay_val = '0;
  logic          tick = 1'b0, irq_mask_en = 1'b0;
  logic          irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, derived from the requirements
  int m_cnt = 0;
  bit m_pend = 0;
  bit m_irq = 0;

  always #10 clk = ~clk;

  txirq_delay_ctrl #(.DLY_W(DW)) u0 (
    .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_report(wb_report),
    .wb_delay_en(wb_delay_en), .delay_val(delay_val), .tick(tick),
    .irq_mask_en(irq_mask_en), .irq_req(irq_req)
  );

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq_req actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive, predict, clock, compare
  task automatic step(bit r, bit v, bit rs, bit de, int dv, bit tk, bit mk, string tag);
    bit rep, fire, arm, ev;
    int ncnt;
    rst = r; wb_valid = v; wb_report = rs; wb_delay_en = de;
    delay_val = DW'(dv); tick = tk; irq_mask_en = mk;
    rep  = v && rs;
    arm  = rep && de && (dv != 0);
    fire = rep && !arm;
    ev   = fire;
    if (arm)                    ncnt = dv;
    else if (fire)              ncnt = 0;
    else if (tk && m_cnt != 0) begin ncnt = m_cnt - 1; ev = (m_cnt == 1); end
    else                        ncnt = m_cnt;
    @(posedge clk); #2;
    if (r) begin m_cnt = 0; m_pend = 0; m_irq = 0; end
    else begin
      m_irq  = mk && (ev || m_pend);
      m_pend = !mk && (ev || m_pend);
      m_cnt  = ncnt;
    end
    check(irq_req, m_irq, tag);
  endtask

  task automatic idle(int n, bit tk, bit mk, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tk, mk, tag);
  endtask

  int pulses;
  task automatic count_idle(int n, string tag);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 0, 1, 1, tag);
      if (irq_req) pulses++;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog irq_req actual=hang expected=done");
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    // R1: reset state and quiet ticks
    step(1, 0, 0, 0, 0, 1, 1, "R1");
    step(1, 1, 1, 0, 0, 1, 1, "R1");
    idle(4, 1, 1, "R1");

    // R2: delay of 5 with a tick every cycle, pulse exactly after 5th tick
    step(0, 1, 1, 1, 5, 0, 1, "R2");
    idle(4, 1, 1, "R2");
    step(0, 0, 0, 0, 0, 1, 1, "R2");
    check(irq_req, 1'b1, "R2");
    idle(3, 1, 1, "R9");

    // R10: load with a tick in the same cycle, then sparse ticks
    step(0, 1, 1, 1, 2, 1, 1, "R10");
    idle(3, 0, 1, "R10");
    step(0, 0, 0, 0, 0, 1, 1, "R10");
    step(0, 0, 0, 0, 0, 1, 1, "R10");
    check(irq_req, 1'b1, "R10");
    idle(2, 0, 1, "R10");

    // R4: reload mid-count, only one pulse in total
    step(0, 1, 1, 1, 3, 0, 1, "R4");
    idle(2, 1, 1, "R4");
    step(0, 1, 1, 1, 4, 1, 1, "R4");
    count_idle(8, "R4");
    checks++;
    if (pulses != 1) begin errors++; $display("FAIL R4 pulses actual=%0d expected=1", pulses); end

    // R5: immediate cancels running countdown
    step(0, 1, 1, 1, 6, 0, 1, "R5");
    idle(2, 1, 1, "R5");
    step(0, 1, 1, 0, 9, 0, 1, "R5");
    check(irq_req, 1'b1, "R5");
    count_idle(10, "R5");
    checks++;
    if (pulses != 0) begin errors++; $display("FAIL R5 pulses actual=%0d expected=0", pulses); end

    // R6: zero delay acts immediately
    step(0, 1, 1, 1, 0, 1, 1, "R6");
    check(irq_req, 1'b1, "R6");
    idle(2, 1, 1, "R6");

    // R8: strobes without report-status mid-count do nothing
    step(0, 1, 1, 1, 4, 0, 1, "R8");
    step(0, 1, 0, 1, 15, 1, 1, "R8");
    step(0, 1, 0, 0, 0, 1, 1, "R8");
    step(0, 1, 0, 1, 1, 1, 1, "R8");
    step(0, 0, 0, 0, 0, 1, 1, "R8");
    check(irq_req, 1'b1, "R8");
    idle(2, 1, 1, "R8");

    // R3/R7: masked expiry held, delivered once on unmask
    step(0, 1, 1, 1, 2, 0, 0, "R7");
    idle(6, 1, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 1, "R7");
    check(irq_req, 1'b1, "R7");
    idle(4, 0, 1, "R7");

    // full-scale delay
    step(0, 1, 1, 1, 15, 0, 1, "R2");
    count_idle(16, "R2");
    checks++;
    if (pulses != 1) begin errors++; $display("FAIL R2 pulses actual=%0d expected=1", pulses); end

    // random mix against the reference
    for (int i = 0; i < 4000; i++) begin
      bit v, rs, de, tk, mk;
      int dv;
      v  = ($urandom % 6) == 0;
      rs = ($urandom % 10) < 7;
      de = ($urandom % 10) < 6;
      dv = $urandom % 16;
      tk = ($urandom % 2) == 0;
      mk = ($urandom % 10) < 8;
      step(($urandom % 997) == 0, v, rs, de, dv, tk, mk, "R9");
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end
endmodule